// File: doc/BRIEF.md
# Packed Saturating Subtractor

This block subtracts two 64-bit operands lane by lane. A two-bit lane-size select splits each operand into one of three shapes: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Lane k always occupies bits k*W up to k*W+W-1, where W is the lane width. Each lane computes operand A minus operand B, and no borrow crosses a lane boundary.

A two-bit mode select picks how a lane result that does not fit is handled. The three choices are:
- keep the low bits (wrap-around);
- clamp to the signed range;
- clamp to the unsigned range.

Each lane clamps on its own, and a per-lane flag reports every clamp. Clamping modes exist only for 8-bit and 16-bit lanes. Asking for them on 32-bit lanes, or using either reserved select code, raises an illegal-request flag.

The result, the clamp flags and the illegal flag are registered. They appear one clock after the operands and selects are presented. This makes the block a single pipeline stage, suited to sit between an operand fetch stage and a writeback stage.

Top module: `psub_sat`

## Requirements
- R1: `lane_sel` encodes the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes, and 3 is reserved. Lane k of the result occupies bits [k*W +: W].
- R2: With `mode_sel` = 0 (wrap), each lane result is (A lane − B lane) modulo 2^W for every legal lane width. No borrow passes between lanes, the clamp flags are all zero and `bad_q` is 0.
- R3: With `mode_sel` = 1 (signed clamp) on 8-bit or 16-bit lanes, the lanes are taken as two's complement. A difference above the largest signed value gives 2^(W−1)−1, and one below the smallest gives −2^(W−1).
- R4: With `mode_sel` = 2 (unsigned clamp) on 8-bit or 16-bit lanes, the lanes are taken as unsigned. When B lane > A lane, the lane result is 0; otherwise it is the exact difference.
- R5: `clamp_q` bit k is 1 exactly when lane k of the registered result was clamped. Bits at and above the lane count are 0.
- R6: A request is illegal when `lane_sel` = 3, when `mode_sel` = 3, or when `lane_sel` = 2 is combined with `mode_sel` 1 or 2. An illegal request gives `bad_q` = 1 with `diff_q` and `clamp_q` all zero.
- R7: The outputs are registered. Inputs sampled at a rising clock edge appear on the outputs just after that edge and do not move the outputs before it.
- R8: A synchronous active-high `rst` clears `diff_q`, `clamp_q` and `bad_q` to zero at the next rising edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | 64 | Left operand (minuend) |
| opnd_b | input | 64 | Right operand (subtrahend) |
| lane_sel | input | 2 | Lane width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| mode_sel | input | 2 | Arithmetic mode: 0 = wrap, 1 = signed clamp, 2 = unsigned clamp, 3 = reserved |
| diff_q | output | 64 | Registered packed difference |
| clamp_q | output | 8 | Registered per-lane clamp flags, bit k for lane k |
| bad_q | output | 1 | Registered illegal-request flag |

## Verification
The clocked properties assume two things about the inputs. First, operands and selects hold known values, free of X, at every rising edge after reset. Second, `rst` is high from time zero, so the first registered values are defined before any property is enabled. The stimulus meets both assumptions. It holds reset high from the start, changes inputs only on falling edges, and draws operand bytes from a set rich in the values where clamping starts: 0x00, 0x01, 0x7F, 0x80 and 0xFF. It sweeps all sixteen select combinations, so every reserved and illegal code is driven with defined data.

// File: rtl/psub_pkg.sv
`timescale 1ns/1ps
package psub_pkg;

  // Lane width select codes
  typedef enum logic [1:0] {
    LN_BYTE  = 2'd0,
    LN_WORD  = 2'd1,
    LN_DWORD = 2'd2,
    LN_RSV   = 2'd3
  } lane_e;

  // Arithmetic mode codes
  typedef enum logic [1:0] {
    MD_WRAP = 2'd0,
    MD_SSAT = 2'd1,
    MD_USAT = 2'd2,
    MD_RSV  = 2'd3
  } mode_e;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int DWORD_W = 32;

endpackage

// File: rtl/psub_lane.sv
`timescale 1ns/1ps
// One subtraction lane of width W with optional signed or unsigned clamping.
module psub_lane
  import psub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  mode_e        mode,
  output logic [W-1:0] res,
  output logic         clamped
);

  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  // Sign-extended difference: one extra bit exposes signed overflow.
  logic [W:0] sdiff;
  logic       s_ovf;
  logic       u_borrow;

  assign sdiff    = {a[W-1], a} - {b[W-1], b};
  assign s_ovf    = sdiff[W] ^ sdiff[W-1];
  assign u_borrow = (a < b);

  always_comb begin
    res     = sdiff[W-1:0];
    clamped = 1'b0;
    unique case (mode)
      MD_SSAT: begin
        if (s_ovf) begin
          res     = sdiff[W] ? S_MIN : S_MAX;
          clamped = 1'b1;
        end
      end
      MD_USAT: begin
        if (u_borrow) begin
          res     = '0;
          clamped = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/psub_bank.sv
`timescale 1ns/1ps
// All lane shapes computed in parallel; the top selects one.
module psub_bank
  import psub_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]         a,
  input  logic [DATA_W-1:0]         b,
  input  mode_e                     mode,
  output logic [DATA_W-1:0]         byte_res,
  output logic [DATA_W/BYTE_W-1:0]  byte_clamp,
  output logic [DATA_W-1:0]         word_res,
  output logic [DATA_W/WORD_W-1:0]  word_clamp,
  output logic [DATA_W-1:0]         dw_res
);

  localparam int NB = DATA_W / BYTE_W;
  localparam int NW = DATA_W / WORD_W;
  localparam int ND = DATA_W / DWORD_W;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    psub_lane #(.W(BYTE_W)) u_lane (
      .a       (a[g*BYTE_W +: BYTE_W]),
      .b       (b[g*BYTE_W +: BYTE_W]),
      .mode    (mode),
      .res     (byte_res[g*BYTE_W +: BYTE_W]),
      .clamped (byte_clamp[g])
    );
  end

  for (genvar g = 0; g < NW; g++) begin : g_word
    psub_lane #(.W(WORD_W)) u_lane (
      .a       (a[g*WORD_W +: WORD_W]),
      .b       (b[g*WORD_W +: WORD_W]),
      .mode    (mode),
      .res     (word_res[g*WORD_W +: WORD_W]),
      .clamped (word_clamp[g])
    );
  end

  // Doubleword lanes only ever wrap.
  for (genvar g = 0; g < ND; g++) begin : g_dword
    assign dw_res[g*DWORD_W +: DWORD_W] =
      a[g*DWORD_W +: DWORD_W] - b[g*DWORD_W +: DWORD_W];
  end

endmodule

// File: rtl/psub_legal.sv
`timescale 1ns/1ps
// Decodes whether a lane-width / mode pairing is supported.
module psub_legal
  import psub_pkg::*;
(
  input  lane_e lane,
  input  mode_e mode,
  output logic  legal
);

  always_comb begin
    legal = 1'b1;
    if (lane == LN_RSV || mode == MD_RSV) begin
      legal = 1'b0;
    end else if (lane == LN_DWORD && mode != MD_WRAP) begin
      legal = 1'b0;
    end
  end

endmodule

// File: rtl/psub_sat.sv
`timescale 1ns/1ps
module psub_sat
  import psub_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        opnd_a,
  input  logic [DATA_W-1:0]        opnd_b,
  input  logic [1:0]               lane_sel,
  input  logic [1:0]               mode_sel,
  output logic [DATA_W-1:0]        diff_q,
  output logic [DATA_W/BYTE_W-1:0] clamp_q,
  output logic                     bad_q
);

  localparam int NB = DATA_W / BYTE_W;
  localparam int NW = DATA_W / WORD_W;

  lane_e lane;
  mode_e mode;
  assign lane = lane_e'(lane_sel);
  assign mode = mode_e'(mode_sel);

  logic [DATA_W-1:0] byte_res, word_res, dw_res;
  logic [NB-1:0]     byte_clamp;
  logic [NW-1:0]     word_clamp;
  logic              legal;

  psub_bank #(.DATA_W(DATA_W)) u_bank (
    .a          (opnd_a),
    .b          (opnd_b),
    .mode       (mode),
    .byte_res   (byte_res),
    .byte_clamp (byte_clamp),
    .word_res   (word_res),
    .word_clamp (word_clamp),
    .dw_res     (dw_res)
  );

  psub_legal u_legal (
    .lane  (lane),
    .mode  (mode),
    .legal (legal)
  );

  logic [DATA_W-1:0] nxt_res;
  logic [NB-1:0]     nxt_clamp;
  logic              nxt_bad;

  always_comb begin
    nxt_res   = '0;
    nxt_clamp = '0;
    nxt_bad   = 1'b0;
    if (!legal) begin
      nxt_bad = 1'b1;
    end else begin
      unique case (lane)
        LN_BYTE: begin
          nxt_res   = byte_res;
          nxt_clamp = byte_clamp;
        end
        LN_WORD: begin
          nxt_res   = word_res;
          nxt_clamp = {{(NB-NW){1'b0}}, word_clamp};
        end
        LN_DWORD: nxt_res = dw_res;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      diff_q  <= '0;
      clamp_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      diff_q  <= nxt_res;
      clamp_q <= nxt_clamp;
      bad_q   <= nxt_bad;
    end
  end

endmodule

// File: rtl/psub_sat_chk.sv
`timescale 1ns/1ps
module psub_sat_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [1:0]        lane_sel,
  input logic [1:0]        mode_sel,
  input logic [DATA_W-1:0] diff_q,
  input logic [DATA_W/8-1:0] clamp_q,
  input logic              bad_q
);

  localparam int NB = DATA_W / 8;
  localparam int NW = DATA_W / 16;

  // R8: reset clears every output at the next edge
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (diff_q == '0 && clamp_q == '0 && !bad_q));

  // R6: saturating mode on 32-bit lanes is flagged and zeroed
  p_dword_sat_bad_r6: assert property (@(posedge clk) disable iff (rst)
    (lane_sel == 2'd2 && mode_sel != 2'd0) |=> (bad_q && diff_q == '0 && clamp_q == '0));

  // R2: wrap mode on a legal width never clamps and is never illegal
  p_wrap_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'd0 && lane_sel != 2'd3) |=> (clamp_q == '0 && !bad_q));

  // R5: 16-bit lanes leave upper clamp bits clear
  p_word_upper_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (lane_sel == 2'd1) |=> (clamp_q[NB-1:NW] == '0));

  // R4: unsigned underflow in byte lane 0 yields zero and a clamp flag
  p_ubyte_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (lane_sel == 2'd0 && mode_sel == 2'd2 && opnd_a[7:0] < opnd_b[7:0])
      |=> (diff_q[7:0] == 8'h00 && clamp_q[0]));

  // R3: a clamped signed byte lane holds one of the two range limits
  p_sbyte_limit_r3: assert property (@(posedge clk) disable iff (rst)
    (lane_sel == 2'd0 && mode_sel == 2'd1)
      |=> (!clamp_q[0] || diff_q[7:0] == 8'h7F || diff_q[7:0] == 8'h80));

  // R7: with inputs held steady and no reset, outputs stay put
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    ($stable(opnd_a) && $stable(opnd_b) && $stable(lane_sel) && $stable(mode_sel) && !$past(rst))
      |=> $stable(diff_q));

endmodule

bind psub_sat psub_sat_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/psub_sat_test.sv
`timescale 1ns/1ps
module psub_sat_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [1:0]  lane_sel = '0;
  logic [1:0]  mode_sel = '0;
  logic [63:0] diff_q;
  logic [7:0]  clamp_q;
  logic        bad_q;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  psub_sat uut (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .lane_sel(lane_sel), .mode_sel(mode_sel),
    .diff_q(diff_q), .clamp_q(clamp_q), .bad_q(bad_q)
  );

  typedef struct {
    logic [63:0] r;
    logic [7:0]  c;
    logic        bad;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  bit   have_last = 0;

  // Behavioural reference built from the requirements.
  function automatic exp_t model(input logic [63:0] a, input logic [63:0] b,
                                 input logic [1:0] ls, input logic [1:0] md,
                                 input logic r_v, input string tag);
    exp_t   e;
    int     w, n;
    longint mask, smax, smin;
    e.r = '0; e.c = '0; e.bad = 1'b0;
    if (tag != "") e.tag = tag;
    else if (r_v) e.tag = "R8";
    else if (ls == 2'd3 || md == 2'd3 || (ls == 2'd2 && md != 2'd0)) e.tag = "R6";
    else if (md == 2'd0) e.tag = "R2";
    else if (md == 2'd1) e.tag = "R3";
    else e.tag = "R4";
    if (r_v) return e;
    if (ls == 2'd3 || md == 2'd3 || (ls == 2'd2 && md != 2'd0)) begin
      e.bad = 1'b1;
      return e;
    end
    w    = 8 << ls;
    n    = 64 / w;
    mask = (longint'(1) << w) - 1;
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -(longint'(1) << (w - 1));
    for (int k = 0; k < n; k++) begin
      longint ua, ub, sa, sb, d, o;
      ua = longint'(a >> (k * w)) & mask;
      ub = longint'(b >> (k * w)) & mask;
      sa = (ua > smax) ? ua - (mask + 1) : ua;
      sb = (ub > smax) ? ub - (mask + 1) : ub;
      o  = 0;
      case (md)
        2'd0: o = ua - ub;
        2'd1: begin
          d = sa - sb;
          if (d > smax) begin o = smax; e.c[k] = 1'b1; end
          else if (d < smin) begin o = smin; e.c[k] = 1'b1; end
          else o = d;
        end
        default: begin
          if (ua < ub) begin o = 0; e.c[k] = 1'b1; end
          else o = ua - ub;
        end
      endcase
      e.r = e.r | (64'(o & mask) << (k * w));
    end
    return e;
  endfunction

  task automatic compare(input exp_t e);
    checks++;
    if (diff_q !== e.r) begin
      errors++;
      $display("FAIL %s result actual=%h expected=%h", e.tag, diff_q, e.r);
    end
    if (clamp_q !== e.c) begin
      errors++;
      $display("FAIL R5 (%s) clamp actual=%b expected=%b", e.tag, clamp_q, e.c);
    end
    if (bad_q !== e.bad) begin
      errors++;
      $display("FAIL R6 (%s) bad actual=%b expected=%b", e.tag, bad_q, e.bad);
    end
  endtask

  // Each call: check the previous cycle's expectation, then apply new inputs.
  task automatic drive(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] ls, input logic [1:0] md,
                       input logic r_v, input string tag);
    @(negedge clk);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e);
      last = e;
      have_last = 1;
    end
    rst = r_v; opnd_a = a; opnd_b = b; lane_sel = ls; mode_sel = md;
    q.push_back(model(a, b, ls, md, r_v, tag));
    #1;
    if (have_last) begin
      // R7: new inputs must not reach the outputs before the edge
      checks++;
      if (diff_q !== last.r) begin
        errors++;
        $display("FAIL R7 early output actual=%h expected=%h", diff_q, last.r);
      end
    end
  endtask

  function automatic logic [63:0] edge_op();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) begin
      case ($urandom % 6)
        0: v[i*8 +: 8] = 8'h00;
        1: v[i*8 +: 8] = 8'h01;
        2: v[i*8 +: 8] = 8'h7F;
        3: v[i*8 +: 8] = 8'h80;
        4: v[i*8 +: 8] = 8'hFF;
        default: v[i*8 +: 8] = 8'($urandom);
      endcase
    end
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: outputs held at zero while reset is high, inputs busy
    drive(64'hFFFF_0000_8000_7F01, 64'h0101_0101_0101_0101, 2'd0, 2'd1, 1'b1, "R8");
    drive(64'hFFFF_0000_8000_7F01, 64'h0101_0101_0101_0101, 2'd0, 2'd2, 1'b1, "R8");
    // R1: lane placement for each width under wrap
    drive(64'h0807_0605_0403_0201, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 1'b0, "R1");
    drive(64'h0004_0003_0002_0001, 64'h0001_0001_0001_0001, 2'd1, 2'd0, 1'b0, "R1");
    // R2: wrap borrows stay inside 32-bit lanes
    drive(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'd2, 2'd0, 1'b0, "R2");
    drive(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 1'b0, "R2");
    // R3: signed byte limits, both directions
    drive(64'h7F7F_8080_0000_7F80, 64'hFF01_0180_0000_FF01, 2'd0, 2'd1, 1'b0, "R3");
    drive(64'h8000_7FFF_0005_8000, 64'h0001_FFFF_0007_7FFF, 2'd1, 2'd1, 1'b0, "R3");
    // R4: unsigned floor and exact differences
    drive(64'h00FF_0010_0001_FF00, 64'h0100_0020_0000_00FF, 2'd0, 2'd2, 1'b0, "R4");
    drive(64'h0000_FFFF_1234_0010, 64'h0001_0000_1235_0010, 2'd1, 2'd2, 1'b0, "R4");
    // R5: equal operands never clamp
    drive(64'h8080_8080_7F7F_7F7F, 64'h8080_8080_7F7F_7F7F, 2'd0, 2'd1, 1'b0, "R5");
    // R6: every illegal pairing
    drive(64'h1, 64'h2, 2'd2, 2'd1, 1'b0, "R6");
    drive(64'h1, 64'h2, 2'd2, 2'd2, 1'b0, "R6");
    drive(64'h1, 64'h2, 2'd3, 2'd0, 1'b0, "R6");
    drive(64'h1, 64'h2, 2'd0, 2'd3, 1'b0, "R6");
    // R7: a back-to-back change of mode shows up one edge later
    drive(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'd0, 2'd2, 1'b0, "R7");
    drive(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 1'b0, "R7");
    // Sweep with clamp-prone operands and occasional reset
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] ls, md;
      logic       r_v;
      ls  = 2'($urandom);
      md  = 2'($urandom);
      r_v = (($urandom % 97) == 0);
      drive(edge_op(), edge_op(), ls, md, r_v, "");
    end
    // Flush the last expectation
    @(negedge clk);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule